// File: doc/BRIEF.md
# Pixel Mute and Sidebar Fill Path

This block sits in the pixel data path of a wide-format display controller, between the video input and the panel pixel stream. On every rising edge of the dot clock it takes one 24-bit RGB pixel, with 8 bits per colour. It also takes the horizontal column index and a frame strobe, both supplied by the raster timing logic. It then decides which of three values the pixel becomes. A blanking request turns the pixel black. In full-width mode the pixel passes through unchanged. In the narrower 4:3 mode, pixels in the side columns are replaced by a flat grey, and the grey level is chosen by a small code.

The grey code is loaded into the block only when the frame strobe goes high and, on that same clock, the function-select input is also high. At any other time the stored grey level stays as it is. Every pixel, whichever way it was decided, leaves the block exactly three dot clocks after it entered. This lets the timing logic delay its own window signals by the same fixed amount.

Top module: `pmp_mute_sidebar`

## Requirements
- R1: While `rst_n` is low, all three output channels are 0 and the stored grey code is 0. The grey code then stays 0 until the first qualified load.
- R2: The pixel sampled at rising edge k appears on the outputs after rising edge k+2. This is three register stages, counting the sampling edge. The outputs then hold that pixel until edge k+3.
- R3: With `full_mode` = 1 and `blank_req` = 0, each output channel equals its input channel in every column.
- R4: With `full_mode` = 0 and `blank_req` = 0, the inputs pass through in columns 107 to 746. In columns 0 to 106, and in columns 747 and above, all three channels carry the grey level instead.
- R5: The grey level is the 3-bit code c repeated from the MSB down, giving {c, c, c[2:1]}. Code 0 gives 0x00, code 4 gives 0x92 and code 7 gives 0xFF.
- R6: `grey_code` is loaded on a rising edge where `frame_strobe` is 1, `frame_strobe` was 0 at the previous edge, and `fn_sel` is 1. The new level applies to pixels sampled from the next edge onward.
- R7: The stored grey code does not change in three cases: when `frame_strobe` rises while `fn_sel` is 0, when `grey_code` changes without a strobe rise, and while `frame_strobe` stays high. In the last case it stays unchanged even if `fn_sel` is raised during the high period.
- R8: When `blank_req` is 1, all 24 output bits of that pixel are 0. This overrides both live video and the sidebar grey.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock; rising edge samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_r | input | 8 | Red input, bit 7 MSB |
| vid_g | input | 8 | Green input, bit 7 MSB |
| vid_b | input | 8 | Blue input, bit 7 MSB |
| blank_req | input | 1 | 1 forces the pixel black |
| full_mode | input | 1 | 1 selects full width, 0 selects 4:3 with sidebars |
| fn_sel | input | 1 | Qualifies loading of the grey code |
| grey_code | input | 3 | Sidebar grey code |
| col_idx | input | 10 | Horizontal column of the current pixel |
| frame_strobe | input | 1 | Frame sync; its rising edge loads the grey code |
| pix_r | output | 8 | Red output |
| pix_g | output | 8 | Green output |
| pix_b | output | 8 | Blue output |

## Verification
Some behaviour is checked by assertions on every cycle:
- the first pipeline stage obeys blanking, full-width pass-through and sidebar fill;
- the grey register loads only on a qualified strobe rise and otherwise holds;
- each later pipeline stage copies the one before it.

Other behaviour is shown only by the bench's scenarios, which compare against a behavioural model. These cover the exact column boundaries at 106/107 and 746/747, the grey values that the codes produce, and the three-clock alignment seen at the ports. They also cover the strobe held high while `fn_sel` is raised, and a strobe rise with `fn_sel` low.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

  localparam int CHAN_W = 8;

  typedef struct packed {
    logic [CHAN_W-1:0] r;
    logic [CHAN_W-1:0] g;
    logic [CHAN_W-1:0] b;
  } rgb_t;

  // Repeat the code bits from the MSB down until the channel is filled.
  function automatic logic [CHAN_W-1:0] grey_expand(input logic [2:0] code);
    logic [CHAN_W-1:0] lvl;
    for (int i = 0; i < CHAN_W; i++) begin
      lvl[CHAN_W-1-i] = code[2 - (i % 3)];
    end
    return lvl;
  endfunction

endpackage

// File: rtl/pmp_grey_reg.sv
module pmp_grey_reg #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_strobe,
  input  logic              fn_sel,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_q
);

  logic              strobe_prev_q;
  logic              load_en;
  logic [CODE_W-1:0] code_d;

  always_comb begin
    load_en = frame_strobe & ~strobe_prev_q & fn_sel;
    code_d  = load_en ? code_in : code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_prev_q <= 1'b0;
      code_q        <= '0;
    end else begin
      strobe_prev_q <= frame_strobe;
      code_q        <= code_d;
    end
  end

  // R6: a qualified strobe rise loads the presented code
  a_r6_load_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && !strobe_prev_q && fn_sel) |=> (code_q == $past(code_in)));

  // R7: without a qualified rise the stored code holds
  a_r7_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_strobe && !strobe_prev_q && fn_sel) |=> $stable(code_q));

endmodule

// File: rtl/pmp_col_zone.sv
module pmp_col_zone #(
  parameter int H_TOTAL = 853,
  parameter int ACTIVE  = 640,
  parameter int COL_W   = 10
) (
  input  logic [COL_W-1:0] col,
  output logic             in_sidebar
);

  localparam int LEFT_W   = (H_TOTAL - ACTIVE + 1) / 2;
  localparam int ACT_LAST = LEFT_W + ACTIVE - 1;

  localparam logic [COL_W-1:0] FIRST_COL = COL_W'(LEFT_W);
  localparam logic [COL_W-1:0] LAST_COL  = COL_W'(ACT_LAST);

  always_comb begin
    in_sidebar = (col < FIRST_COL) || (col > LAST_COL);
  end

endmodule

// File: rtl/pmp_delay.sv
module pmp_delay #(
  parameter int W     = 24,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage_q [DEPTH+1];

  always_comb stage_q[0] = din;

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s+1] <= '0;
      else        stage_q[s+1] <= stage_q[s];
    end

    // R2: each stage copies the previous one with exactly one clock of delay
    a_r2_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (stage_q[s+1] == $past(stage_q[s])));
  end

  always_comb dout = stage_q[DEPTH];

endmodule

// File: rtl/pmp_mute_sidebar.sv
module pmp_mute_sidebar
  import pmp_pkg::*;
#(
  parameter int H_TOTAL    = 853,
  parameter int ACTIVE     = 640,
  parameter int PIPE_DEPTH = 3,
  localparam int COL_W     = $clog2(H_TOTAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        vid_r,
  input  logic [7:0]        vid_g,
  input  logic [7:0]        vid_b,
  input  logic              blank_req,
  input  logic              full_mode,
  input  logic              fn_sel,
  input  logic [2:0]        grey_code,
  input  logic [COL_W-1:0]  col_idx,
  input  logic              frame_strobe,
  output logic [7:0]        pix_r,
  output logic [7:0]        pix_g,
  output logic [7:0]        pix_b
);

  localparam int TAIL   = PIPE_DEPTH - 1;
  localparam int RGB_W  = $bits(rgb_t);

  logic [2:0] grey_q;
  logic       in_side;
  rgb_t       live_px;
  rgb_t       grey_px;
  rgb_t       sel_d;
  rgb_t       sel_q;
  rgb_t       out_px;

  pmp_grey_reg #(.CODE_W(3)) u_grey (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_strobe (frame_strobe),
    .fn_sel       (fn_sel),
    .code_in      (grey_code),
    .code_q       (grey_q)
  );

  pmp_col_zone #(.H_TOTAL(H_TOTAL), .ACTIVE(ACTIVE), .COL_W(COL_W)) u_zone (
    .col        (col_idx),
    .in_sidebar (in_side)
  );

  always_comb begin
    live_px = '{r: vid_r, g: vid_g, b: vid_b};
    grey_px = '{r: grey_expand(grey_q), g: grey_expand(grey_q), b: grey_expand(grey_q)};
    if (blank_req)                 sel_d = '0;
    else if (full_mode || !in_side) sel_d = live_px;
    else                           sel_d = grey_px;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  pmp_delay #(.W(RGB_W), .DEPTH(TAIL)) u_tail (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (sel_q),
    .dout  (out_px)
  );

  always_comb begin
    pix_r = out_px.r;
    pix_g = out_px.g;
    pix_b = out_px.b;
  end

  // R8: blanking zeroes the pixel regardless of mode or column
  a_r8_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
    blank_req |=> (sel_q == '0));

  // R3: full width passes the input unchanged
  a_r3_full_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_req && full_mode) |=> (sel_q == $past(live_px)));

  // R4: sidebar columns in 4:3 mode carry the stored grey on all channels
  a_r4_side_grey: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_req && !full_mode && in_side) |=>
      (sel_q.r == sel_q.g && sel_q.g == sel_q.b &&
       sel_q.r == grey_expand($past(grey_q))));

endmodule

// File: tb/pmp_mute_sidebar_bench.sv
module pmp_mute_sidebar_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic [7:0] vid_r, vid_g, vid_b;
  logic       blank_req, full_mode, fn_sel, frame_strobe;
  logic [2:0] grey_code;
  logic [9:0] col_idx;
  logic [7:0] pix_r, pix_g, pix_b;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  pmp_mute_sidebar u_pmp_mute_sidebar (
    .clk(clk), .rst_n(rst_n),
    .vid_r(vid_r), .vid_g(vid_g), .vid_b(vid_b),
    .blank_req(blank_req), .full_mode(full_mode), .fn_sel(fn_sel),
    .grey_code(grey_code), .col_idx(col_idx), .frame_strobe(frame_strobe),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  logic [2:0]  m_grey;
  logic        m_prev_fs;
  logic [23:0] m_pipe [3];
  string       m_tag  [3];
  string       cur_tag = "R1";

  function automatic logic [7:0] lvl(input logic [2:0] c);
    return {c, c, c[2:1]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_grey = 0; m_prev_fs = 0;
      for (int i = 0; i < 3; i++) begin m_pipe[i] = 0; m_tag[i] = "R1"; end
    end else begin
      logic [23:0] e;
      if (blank_req) e = 24'h0;
      else if (full_mode || (col_idx >= 107 && col_idx <= 746)) e = {vid_r, vid_g, vid_b};
      else e = {3{lvl(m_grey)}};
      m_pipe[2] = m_pipe[1]; m_tag[2] = m_tag[1];
      m_pipe[1] = m_pipe[0]; m_tag[1] = m_tag[0];
      m_pipe[0] = e;         m_tag[0] = cur_tag;
      if (frame_strobe && !m_prev_fs && fn_sel) m_grey = grey_code;
      m_prev_fs = frame_strobe;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      logic [23:0] act, exp_v;
      string t;
      act = {pix_r, pix_g, pix_b};
      if (!rst_n) begin exp_v = 0; t = "R1"; end
      else begin exp_v = m_pipe[2]; t = m_tag[2]; end
      vectors++;
      if (act !== exp_v) begin
        errors++;
        $display("FAIL %s (R2 alignment) actual=%06h expected=%06h t=%0t", t, act, exp_v, $time);
      end
    end
  end

  task automatic drive(input logic [23:0] rgb, input logic [9:0] col,
                       input logic blk, input logic full);
    {vid_r, vid_g, vid_b} = rgb;
    col_idx = col; blank_req = blk; full_mode = full;
    @(negedge clk);
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) drive(24'h0, 10'd400, 1'b0, 1'b1);
  endtask

  task automatic strobe(input logic [2:0] code, input logic fn);
    grey_code = code; fn_sel = fn; frame_strobe = 1;
    drive(24'h0, 10'd400, 1'b1, 1'b1);
    frame_strobe = 0; fn_sel = 0;
    drive(24'h0, 10'd400, 1'b1, 1'b1);
  endtask

  task automatic sweep_edges(input logic [23:0] rgb);
    for (int c = 103; c <= 110; c++) drive(rgb ^ 24'(c), 10'(c), 1'b0, 1'b0);
    for (int c = 743; c <= 750; c++) drive(rgb ^ 24'(c), 10'(c), 1'b0, 1'b0);
    drive(rgb, 10'd0, 1'b0, 1'b0);
    drive(rgb, 10'd852, 1'b0, 1'b0);
    drive(rgb, 10'd1000, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 0; fn_sel = 0; frame_strobe = 0; grey_code = 3'd5;
    vid_r = 8'h11; vid_g = 8'h22; vid_b = 8'h33;
    blank_req = 0; full_mode = 0; col_idx = 10'd0;
    cur_tag = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1: grey is 0 after reset, visible in the sidebar
    sweep_edges(24'hA5C3E1);

    // R2: single marked pixel among zeros
    cur_tag = "R2";
    flush();
    drive(24'hDEADBE, 10'd300, 1'b0, 1'b1);
    flush();

    // R3: full width, random pixels, all column regions
    cur_tag = "R3";
    for (int i = 0; i < 60; i++)
      drive(24'($urandom), 10'($urandom_range(0, 852)), 1'b0, 1'b1);
    sweep_edges(24'h5A5A5A);

    // R6 / R5: load code 4 -> 0x92
    cur_tag = "R6";
    strobe(3'd4, 1'b1);
    cur_tag = "R5";
    sweep_edges(24'h010203);
    // R4: normal mode, random columns
    cur_tag = "R4";
    for (int i = 0; i < 60; i++)
      drive(24'($urandom), 10'($urandom_range(0, 852)), 1'b0, 1'b0);

    // R7: strobe with fn_sel low does not load
    cur_tag = "R7";
    strobe(3'd7, 1'b0);
    sweep_edges(24'h777777);
    // R7: code change without strobe
    grey_code = 3'd1; fn_sel = 1;
    sweep_edges(24'h123456);
    fn_sel = 0;
    // R7: strobe held high, fn_sel raised mid-pulse
    grey_code = 3'd2; frame_strobe = 1;
    drive(24'h0, 10'd50, 1'b0, 1'b0);
    fn_sel = 1;
    for (int c = 0; c < 6; c++) drive(24'h0, 10'(c * 20), 1'b0, 1'b0);
    frame_strobe = 0; fn_sel = 0;
    sweep_edges(24'h654321);

    // R5: codes 7 and 0
    cur_tag = "R5";
    strobe(3'd7, 1'b1);
    sweep_edges(24'h0F0F0F);
    strobe(3'd0, 1'b1);
    sweep_edges(24'hF0F0F0);
    strobe(3'd3, 1'b1);

    // R8: blank in sidebar and active, both modes
    cur_tag = "R8";
    for (int i = 0; i < 40; i++)
      drive(24'($urandom) | 24'h1, 10'($urandom_range(0, 852)), 1'b1, 1'(i % 2));
    drive(24'hFFFFFF, 10'd5, 1'b1, 1'b0);
    drive(24'hFFFFFF, 10'd500, 1'b1, 1'b0);
    drive(24'hFFFFFF, 10'd500, 1'b0, 1'b0);
    drive(24'hFFFFFF, 10'd5, 1'b0, 1'b0);

    // R1: reset mid-stream clears outputs and grey
    cur_tag = "R1";
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    sweep_edges(24'h0C0C0C);
    flush();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule